// File: doc/BRIEF.md
# Programmable Duty-Cycle Frequency Divider

This block divides a single-bit input clock by a programmable integer. Every rising edge of the input advances an internal phase counter. That counter runs from zero up to the divisor minus one and then wraps. The output is a registered level that is high while the phase is below a programmable high-time and low for the rest of the period. The output therefore has a programmable period and a programmable duty cycle, and every output transition lines up with a rising input edge.

A synchronous, active-high reset loads a programmable start phase. This lets the output begin partway through a period. Out-of-range settings are repaired inside the block:
- A divisor of zero is treated as one.
- The high-time is clamped into its legal window.
- A start phase at or above the divisor is reduced modulo the divisor.

New settings are adopted only at reset or when the counter wraps. A period in progress is never cut short or stretched.

Top module: `pdc_divider`

## Requirements
- R1: On a rising input edge with reset high, the phase counter loads the start phase (after reduction, see R6) and the divisor and high-time settings are adopted. The output after that edge is high exactly when the start phase is below the adopted high-time.
- R2: Outside reset the output repeats with a period of exactly D rising input edges, where D is the adopted divisor. The phase steps by one per edge and wraps from D-1 to 0.
- R3: Within each period the output is high for exactly H consecutive edges, phases 0 to H-1, and low for the remaining D-H edges, where H is the adopted high-time.
- R4: A high-time setting of 0 is used as 1. A high-time setting of D or more is used as D-1, for any D of at least 2.
- R5: A divisor setting of 0 is used as 1. With an adopted divisor of 1, the output stays low on every edge.
- R6: A start phase setting of D or more is reduced to its remainder modulo D before it is loaded.
- R7: Changes to the divisor or high-time inputs take effect only on the edge where the phase wraps from D-1 to 0, or on a reset edge. Until then the running period keeps its old settings.
- R8: Divisor 5, high-time 3 and start phase 4 give one low output after reset. The output then repeats high for three edges and low for two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frequency input; all state advances on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset; loads start phase and settings |
| divisor_i | input | W | Requested period in input cycles |
| high_i | input | W | Requested number of high cycles per period |
| preset_i | input | W | Requested phase loaded at reset |
| out_o | output | 1 | Divided, registered output |

## Verification
A wrap of the phase counter and a change of the divisor or high-time inputs can fall on the same edge. In that case the new settings must be taken at once and must set the first phase of the new period. Random settings are therefore changed on random edges, so that many changes land exactly on the wrap edge and many land in mid-period. A per-edge reference model in the bench judges both cases by adopting settings only at wrap or reset. A reset can also coincide with a wrap; reset must win, loading the start phase instead of zero, and random reset pulses provoke this.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    // Default width of the divisor, high-time and phase fields.
    localparam int unsigned PDC_DEFAULT_W = 8;
endpackage

// File: rtl/pdc_cfg_sanitize.sv
module pdc_cfg_sanitize #(
    parameter int unsigned W = pdc_pkg::PDC_DEFAULT_W
) (
    input  logic [W-1:0] divisor_raw,
    input  logic [W-1:0] high_raw,
    input  logic [W-1:0] preset_raw,
    output logic [W-1:0] div_ok,
    output logic [W-1:0] high_ok,
    output logic [W-1:0] start_ok
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    always_comb begin
        // a zero divisor behaves as one
        div_ok = (divisor_raw == ZERO) ? ONE : divisor_raw;

        // clamp high-time into 1 .. div-1; nothing legal when div is 1
        if (div_ok == ONE)
            high_ok = ZERO;
        else if (high_raw == ZERO)
            high_ok = ONE;
        else if (high_raw >= div_ok)
            high_ok = div_ok - ONE;
        else
            high_ok = high_raw;

        // fold an oversized start phase back into the period
        start_ok = preset_raw % div_ok;
    end
endmodule

// File: rtl/pdc_phase_step.sv
module pdc_phase_step #(
    parameter int unsigned W = pdc_pkg::PDC_DEFAULT_W
) (
    input  logic [W-1:0] phase,
    input  logic [W-1:0] div,
    output logic         at_end,
    output logic [W-1:0] phase_inc
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        at_end    = (phase == div - ONE);
        phase_inc = phase + ONE;
    end
endmodule

// File: rtl/pdc_divider.sv
module pdc_divider #(
    parameter int unsigned W = pdc_pkg::PDC_DEFAULT_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] divisor_i,
    input  logic [W-1:0] high_i,
    input  logic [W-1:0] preset_i,
    output logic         out_o
);
    typedef struct packed {
        logic [W-1:0] phase;
        logic [W-1:0] div;
        logic [W-1:0] high;
        logic         level;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] div_s, high_s, start_s;
    logic         at_end;
    logic [W-1:0] phase_inc;

    pdc_cfg_sanitize #(.W(W)) u_cfg (
        .divisor_raw (divisor_i),
        .high_raw    (high_i),
        .preset_raw  (preset_i),
        .div_ok      (div_s),
        .high_ok     (high_s),
        .start_ok    (start_s)
    );

    pdc_phase_step #(.W(W)) u_step (
        .phase     (st_q.phase),
        .div       (st_q.div),
        .at_end    (at_end),
        .phase_inc (phase_inc)
    );

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.div   = div_s;
            st_d.high  = high_s;
            st_d.phase = start_s;
        end else if (at_end) begin
            // settings are adopted only at the period boundary
            st_d.div   = div_s;
            st_d.high  = high_s;
            st_d.phase = '0;
        end else begin
            st_d.phase = phase_inc;
        end
        st_d.level = (st_d.phase < st_d.high);
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign out_o = st_q.level;

    // flat views for the bound checker
    logic [W-1:0] phase_q, div_q, high_q;
    assign phase_q = st_q.phase;
    assign div_q   = st_q.div;
    assign high_q  = st_q.high;
endmodule

// File: rtl/pdc_divider_chk.sv
module pdc_divider_chk #(
    parameter int unsigned W = pdc_pkg::PDC_DEFAULT_W
) (
    input logic         clk,
    input logic         rst,
    input logic         out,
    input logic [W-1:0] phase,
    input logic [W-1:0] div,
    input logic [W-1:0] high
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // R1
    phase_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase < div);

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == div - ONE) |=> (rst || phase == '0));

    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != div - ONE) |=> (rst || phase == $past(phase) + ONE));

    // R3
    high_only_early_chk: assert property (@(posedge clk) disable iff (rst)
        out |-> (phase < high));

    // R4
    high_below_div_chk: assert property (@(posedge clk) disable iff (rst)
        high < div);

    // R5
    div_one_low_chk: assert property (@(posedge clk) disable iff (rst)
        (div == ONE) |-> !out);

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != div - ONE) |=> (rst || ($stable(div) && $stable(high))));
endmodule

bind pdc_divider pdc_divider_chk #(.W(W)) u_chk (
    .clk   (clk_i),
    .rst   (rst_i),
    .out   (out_o),
    .phase (phase_q),
    .div   (div_q),
    .high  (high_q)
);

// File: tb/tb_pdc_divider.sv
module tb_pdc_divider;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] divisor = 8'd2;
    logic [W-1:0] high    = 8'd1;
    logic [W-1:0] preset  = 8'd0;
    logic         out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state
    int m_phase = 0, m_div = 1, m_high = 0;
    bit m_valid = 0;

    pdc_divider #(.W(W)) dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .divisor_i (divisor),
        .high_i    (high),
        .preset_i  (preset),
        .out_o     (out)
    );

    always #10 clk = ~clk;

    function automatic int fix_div(int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int fix_high(int d, int h);
        if (d == 1) return 0;
        if (h == 0) return 1;
        if (h >= d) return d - 1;
        return h;
    endfunction

    // reference model, one update per rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_div   = fix_div(int'(divisor));
            m_high  = fix_high(m_div, int'(high));
            m_phase = int'(preset) % m_div;
            m_valid = 1;
        end else if (m_valid) begin
            if (m_phase == m_div - 1) begin
                m_div   = fix_div(int'(divisor));
                m_high  = fix_high(m_div, int'(high));
                m_phase = 0;
            end else begin
                m_phase = m_phase + 1;
            end
        end
        cycles++;
    end

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: out=%0b expected %0b (t=%0t)", req, act, exp, $time);
        end
    endtask

    // one edge, then compare at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_bit(tag, out, logic'(m_phase < m_high));
    endtask

    task automatic do_reset(int d, int h, int p, int n);
        divisor = W'(d); high = W'(h); preset = W'(p);
        rst = 1'b1;
        for (int i = 0; i < n; i++) tick();
        rst = 1'b0;
    endtask

    // watchdog
    initial begin
        wait (cycles > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [9:0] pat;
        void'($urandom(1234));
        @(negedge clk);

        // R1 reset state with a mid-period start phase
        tag = "R1";
        do_reset(6, 2, 1, 2);
        for (int i = 0; i < 14; i++) tick();

        // R8 directed example: 5 / 3 / 4
        tag = "R8";
        divisor = 8'd5; high = 8'd3; preset = 8'd4; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check_bit("R8", out, 1'b0);
        rst = 1'b0;
        pat = 10'b0011100111; // bit i is the output i edges after release
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); @(negedge clk);
            check_bit("R8", out, pat[i]);
        end

        // R2 R3 plain periods
        tag = "R2 R3";
        do_reset(7, 4, 0, 1);
        for (int i = 0; i < 21; i++) tick();

        // R4 clamping of high-time
        tag = "R4";
        do_reset(4, 9, 0, 1);
        for (int i = 0; i < 12; i++) tick();
        do_reset(5, 0, 0, 1);
        for (int i = 0; i < 10; i++) tick();

        // R5 divisor zero and one keep output low
        tag = "R5";
        do_reset(0, 3, 2, 1);
        for (int i = 0; i < 6; i++) tick();
        do_reset(1, 1, 0, 1);
        for (int i = 0; i < 6; i++) tick();

        // R6 oversized start phase
        tag = "R6";
        do_reset(4, 2, 9, 1);
        for (int i = 0; i < 8; i++) tick();

        // R7 change mid-period, old period must finish
        tag = "R7";
        do_reset(6, 3, 0, 1);
        tick(); tick();
        divisor = 8'd3; high = 8'd1;
        for (int i = 0; i < 12; i++) tick();

        // random settings, changes on random edges, random resets
        tag = "R2 R3 R7";
        for (int seg = 0; seg < 40; seg++) begin
            do_reset($urandom_range(0, 12), $urandom_range(0, 14),
                     $urandom_range(0, 20), 1);
            for (int i = 0; i < 40; i++) begin
                if ($urandom_range(0, 3) == 0) begin
                    divisor = W'($urandom_range(0, 12));
                    high    = W'($urandom_range(0, 14));
                end
                rst = ($urandom_range(0, 29) == 0);
                tick();
            end
            rst = 1'b0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule